// File: doc/BRIEF.md
# CPU Hotplug Register Controller

This block is a small I/O-mapped register window that tracks hot-add and hot-remove state for a fixed set of CPU slots. Each slot holds three flags: enabled, insert pending and remove pending. A host reaches these flags through one selected slot. A dword write chooses the slot, and later status reads and control writes act on that slot only.

A command byte sets the meaning of a shared dword data register. Command 0 starts a scan for the next slot that has an event pending, and the selector then moves to that slot. Command 1 makes data writes land in an OST event register. Command 2 makes data writes land in an OST status register and raises a one-cycle notify pulse, which presents both OST values on the outputs.

Hot-add request pulses come in from the platform, one bit per slot. A level interrupt stays high while any slot has a pending event.

Top module: `cpu_hp_regs`

## Requirements
- R1: After reset, the selector is 0, the command is 0, every slot flag is clear, `irq` is low and both OST registers are 0.
- R2: A dword write at offset 0x0 loads the selector. While the command is 0, a dword read at offset 0x8 returns the selector value.
- R3: A byte read at offset 0x4 returns the selected slot's status: bit 0 is enabled, bit 1 is insert pending, bit 2 is remove pending, and bits 7..3 read as 0.
- R4: In a byte write at offset 0x4, bit 1 = 1 clears the selected slot's insert flag and bit 2 = 1 clears its remove flag. Bit 0 and bits 7..4 have no effect.
- R5: In a byte write at offset 0x4, bit 3 = 1 ejects the selected slot if it is enabled: enabled and insert are cleared and remove is set. On a slot that is not enabled, bit 3 has no effect.
- R6: A pulse on `hp_add[k]` sets both enabled and insert for slot k. The insert flag is never set while enabled is clear.
- R7: `irq` is high exactly while at least one slot has insert or remove pending.
- R8: A byte write of 0 at offset 0x5 sets command 0 and starts a scan. The scan tests slots in ascending order, starting at selector+1 and wrapping, with the selected slot tested last. When the selector is out of range, the scan starts at slot 0. The first slot found with a pending event becomes the selector. If no slot is found, the selector stays the same.
- R9: For NUM_SLOTS+1 cycles after the scan command is accepted, `req_ready` is low, so no access completes before the selector holds its new value.
- R10: While the command is 1, a dword write at 0x8 stores the value in `ost_event`. While the command is 2, the write stores it in `ost_status` and `ost_notify` is high for exactly the cycle after the write.
- R11: A dword read at 0x8 while the command is not 0 returns 0xFFFFFFFF.
- R12: While the selector is NUM_SLOTS or more, control writes at 0x4 change no slot and status reads at 0x4 return 0.
- R13: Accesses at reserved offsets (0x0 read, 0x5 to 0x7 read, 0x6 and 0x7 write), accesses outside the 12-byte window, and accesses with the wrong width are ignored, and such reads return 0.
- R14: Each accepted read produces exactly one `rsp_valid` pulse, one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dword | input | 1 | 1 = dword access, 0 = byte access |
| req_addr | input | 8 | Byte offset of the access |
| req_wdata | input | 32 | Write data (byte accesses use bits 7..0) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| hp_add | input | NUM_SLOTS | Hot-add request pulse, one bit per slot |
| irq | output | 1 | Level interrupt, high while any event is pending |
| ost_notify | output | 1 | One-cycle pulse after an OST status write |
| ost_event | output | 32 | OST event register |
| ost_status | output | 32 | OST status register |

## Verification
A wrong slot flag shows at the ports in two ways. It appears as a wrong status byte in the read response one cycle after the next status read of that slot. It also appears at once as a wrong `irq` level, because the interrupt follows the flags combinationally. A scan that visits slots in the wrong order, or that fails to wrap, leaves a different selector, and that shows on the first command-0 data read after `req_ready` returns. The bench measures the stall length directly so that an early or late release is caught. Writes that should be ignored are checked by reading the affected slot or the selector back through the normal window.

// File: rtl/cpu_hp_pkg.sv
package cpu_hp_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CMD_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_SEL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h05;
    localparam logic [ADDR_W-1:0] OFS_DATA = 8'h08;

    localparam logic [CMD_W-1:0] CMD_SCAN   = 8'd0;
    localparam logic [CMD_W-1:0] CMD_OST_EV = 8'd1;
    localparam logic [CMD_W-1:0] CMD_OST_ST = 8'd2;

    localparam int BIT_EN    = 0;
    localparam int BIT_INS   = 1;
    localparam int BIT_REM   = 2;
    localparam int BIT_EJECT = 3;

    typedef struct packed {
        logic en;
        logic ins;
        logic rem;
    } slot_t;
endpackage

// File: rtl/cpu_hp_slots.sv
module cpu_hp_slots #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     hp_add,
    input  logic             ctl_we,
    input  logic [IDX_W-1:0] ctl_idx,
    input  logic             ctl_clr_ins,
    input  logic             ctl_clr_rem,
    input  logic             ctl_eject,
    output logic [N-1:0]     en,
    output logic [N-1:0]     ins,
    output logic [N-1:0]     rem
);
    import cpu_hp_pkg::*;

    for (genvar g = 0; g < N; g++) begin : g_slot
        slot_t s_d, s_q;
        logic  hit;

        always_comb begin
            s_d = s_q;
            hit = ctl_we && (ctl_idx == IDX_W'(g));
            if (hit) begin
                if (ctl_clr_ins) s_d.ins = 1'b0;
                if (ctl_clr_rem) s_d.rem = 1'b0;
                if (ctl_eject && s_q.en) begin
                    s_d.en  = 1'b0;
                    s_d.ins = 1'b0;
                    s_d.rem = 1'b1;
                end
            end
            if (hp_add[g]) begin
                s_d.en  = 1'b1;
                s_d.ins = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        assign en[g]  = s_q.en;
        assign ins[g] = s_q.ins;
        assign rem[g] = s_q.rem;
    end
endmodule

// File: rtl/cpu_hp_scan.sv
module cpu_hp_scan #(
    parameter int N     = 8,
    parameter int SEL_W = 32,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEL_W-1:0] start_sel,
    input  logic [N-1:0]     pending,
    output logic             busy,
    output logic             done,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] cand;
        logic [IDX_W-1:0] cnt;
    } scan_t;

    scan_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (!st_q.hit && pending[st_q.cand]) begin
                st_d.hit = 1'b1;
                st_d.idx = st_q.cand;
            end
            st_d.cand = (st_q.cand == LAST) ? '0 : st_q.cand + 1'b1;
            st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.hit  = 1'b0;
            st_d.cnt  = '0;
            if (start_sel < SEL_W'(N)) begin
                st_d.cand = (start_sel[IDX_W-1:0] == LAST) ? '0
                          : start_sel[IDX_W-1:0] + 1'b1;
            end else begin
                st_d.cand = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign hit     = st_q.hit;
    assign hit_idx = st_q.idx;
endmodule

// File: rtl/cpu_hp_regs.sv
module cpu_hp_regs #(
    parameter int NUM_SLOTS = 8,
    parameter int SEL_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic                 req_dword,
    input  logic [7:0]           req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    input  logic [NUM_SLOTS-1:0] hp_add,
    output logic                 irq,
    output logic                 ost_notify,
    output logic [31:0]          ost_event,
    output logic [31:0]          ost_status
);
    import cpu_hp_pkg::*;

    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] ost_ev;
        logic [DATA_W-1:0] ost_st;
        logic              notify;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
    } regs_t;

    regs_t st_d, st_q;

    logic [NUM_SLOTS-1:0] slot_en, slot_ins, slot_rem, pending;
    logic                 scan_busy, scan_done, scan_hit, scan_start;
    logic [IDX_W-1:0]     scan_idx;
    logic [SEL_W-1:0]     sel_q;

    logic acc, wr, rd, in_range;
    logic dec_sel, dec_stat, dec_cmd, dec_data;
    logic ctl_we;
    logic [IDX_W-1:0]  cur_idx;
    logic [7:0]        stat_byte;
    logic [DATA_W-1:0] rd_mux;

    assign sel_q    = st_q.sel;
    assign pending  = slot_ins | slot_rem;
    assign in_range = st_q.sel < SEL_W'(NUM_SLOTS);
    assign cur_idx  = st_q.sel[IDX_W-1:0];

    assign req_ready = !scan_busy && !scan_done;
    assign acc       = req_valid && req_ready;
    assign wr        = acc && req_write;
    assign rd        = acc && !req_write;

    assign dec_sel  = (req_addr == OFS_SEL)  &&  req_dword;
    assign dec_stat = (req_addr == OFS_STAT) && !req_dword;
    assign dec_cmd  = (req_addr == OFS_CMD)  && !req_dword;
    assign dec_data = (req_addr == OFS_DATA) &&  req_dword;

    assign ctl_we     = wr && dec_stat && in_range;
    assign scan_start = wr && dec_cmd && (req_wdata[CMD_W-1:0] == CMD_SCAN);

    always_comb begin
        stat_byte = '0;
        if (in_range) begin
            stat_byte[BIT_EN]  = slot_en[cur_idx];
            stat_byte[BIT_INS] = slot_ins[cur_idx];
            stat_byte[BIT_REM] = slot_rem[cur_idx];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (dec_stat) begin
            rd_mux = DATA_W'(stat_byte);
        end else if (dec_data) begin
            rd_mux = (st_q.cmd == CMD_SCAN) ? DATA_W'(st_q.sel) : '1;
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.notify = 1'b0;
        st_d.rsp_v  = rd;
        st_d.rsp_d  = rd ? rd_mux : '0;
        if (wr && dec_sel) begin
            st_d.sel = req_wdata[SEL_W-1:0];
        end
        if (wr && dec_cmd) begin
            st_d.cmd = req_wdata[CMD_W-1:0];
        end
        if (wr && dec_data) begin
            if (st_q.cmd == CMD_OST_EV) begin
                st_d.ost_ev = req_wdata;
            end else if (st_q.cmd == CMD_OST_ST) begin
                st_d.ost_st = req_wdata;
                st_d.notify = 1'b1;
            end
        end
        if (scan_done && scan_hit) begin
            st_d.sel = SEL_W'(scan_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cpu_hp_slots #(.N(NUM_SLOTS), .IDX_W(IDX_W)) slots_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hp_add      (hp_add),
        .ctl_we      (ctl_we),
        .ctl_idx     (cur_idx),
        .ctl_clr_ins (req_wdata[BIT_INS]),
        .ctl_clr_rem (req_wdata[BIT_REM]),
        .ctl_eject   (req_wdata[BIT_EJECT]),
        .en          (slot_en),
        .ins         (slot_ins),
        .rem         (slot_rem)
    );

    cpu_hp_scan #(.N(NUM_SLOTS), .SEL_W(SEL_W), .IDX_W(IDX_W)) scan_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (scan_start),
        .start_sel (st_q.sel),
        .pending   (pending),
        .busy      (scan_busy),
        .done      (scan_done),
        .hit       (scan_hit),
        .hit_idx   (scan_idx)
    );

    assign irq        = |pending;
    assign rsp_valid  = st_q.rsp_v;
    assign rsp_rdata  = st_q.rsp_d;
    assign ost_notify = st_q.notify;
    assign ost_event  = st_q.ost_ev;
    assign ost_status = st_q.ost_st;
endmodule

// File: rtl/cpu_hp_regs_chk.sv
module cpu_hp_regs_chk #(
    parameter int NUM_SLOTS = 8,
    parameter int SEL_W     = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_write,
    input logic                 req_dword,
    input logic [7:0]           req_addr,
    input logic [NUM_SLOTS-1:0] hp_add,
    input logic                 irq,
    input logic                 rsp_valid,
    input logic                 ost_notify,
    input logic [NUM_SLOTS-1:0] slot_en,
    input logic [NUM_SLOTS-1:0] slot_ins,
    input logic                 scan_busy,
    input logic [SEL_W-1:0]     sel_q
);
    logic rd_acc;
    assign rd_acc = req_valid && req_ready && !req_write;

    p_ins_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_ins & ~slot_en) == '0);

    p_add_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|hp_add) |=> irq);

    p_rsp_follows_r14: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rsp_valid);

    p_rsp_only_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !rsp_valid);

    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_busy |-> !req_ready);

    p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_busy |=> $stable(sel_q));

    p_notify_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ost_notify |-> $past(req_valid && req_ready && req_write && req_dword
                             && req_addr == 8'h08));
endmodule

bind cpu_hp_regs cpu_hp_regs_chk #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_dword  (req_dword),
    .req_addr   (req_addr),
    .hp_add     (hp_add),
    .irq        (irq),
    .rsp_valid  (rsp_valid),
    .ost_notify (ost_notify),
    .slot_en    (slot_en),
    .slot_ins   (slot_ins),
    .scan_busy  (scan_busy),
    .sel_q      (sel_q)
);

// File: tb/cpu_hp_regs_tb_top.sv
module cpu_hp_regs_tb_top;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_dword = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [N-1:0] hp_add = '0;
    logic        irq, ost_notify;
    logic [31:0] ost_event, ost_status;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    cpu_hp_regs #(.NUM_SLOTS(N), .SEL_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_dword(req_dword), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .hp_add(hp_add), .irq(irq), .ost_notify(ost_notify),
        .ost_event(ost_event), .ost_status(ost_status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected item per read response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R14 unexpected response actual=0x%08h expected=none", rsp_rdata);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic xfer(input bit wr, input bit dw, input logic [7:0] a, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_dword = dw; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_exp(input bit dw, input logic [7:0] a, input logic [31:0] exp, input string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        xfer(1'b0, dw, a, 32'h0);
    endtask

    task automatic pulse_add(input int k);
        @(negedge clk);
        hp_add = N'(1) << k;
        @(negedge clk);
        hp_add = '0;
    endtask

    task automatic wr_sel(input logic [31:0] v);  xfer(1'b1, 1'b1, 8'h00, v); endtask
    task automatic wr_ctl(input logic [7:0] v);   xfer(1'b1, 1'b0, 8'h04, {24'h0, v}); endtask
    task automatic wr_cmd(input logic [7:0] v);   xfer(1'b1, 1'b0, 8'h05, {24'h0, v}); endtask

    task automatic scan_and_count(output int stall);
        wr_cmd(8'h00);
        stall = 0;
        while (!req_ready) begin
            stall++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int stall;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 ost_event", ost_event, 32'h0);
        check("R1 ost_status", ost_status, 32'h0);
        rd_exp(1'b1, 8'h08, 32'h0, "R1 selector");
        rd_exp(1'b0, 8'h04, 32'h0, "R1 status");

        // R6 hot add, R7 irq, R2 selector, R3 status layout
        pulse_add(3);
        check("R7 irq after add", 32'(irq), 32'h1);
        wr_sel(32'd3);
        rd_exp(1'b0, 8'h04, 32'h03, "R6 R3 status after add");
        rd_exp(1'b1, 8'h08, 32'd3, "R2 selector readback");

        // R4 ignored bits, then clear insert
        wr_ctl(8'hF1);
        rd_exp(1'b0, 8'h04, 32'h03, "R4 ignored bits");
        wr_ctl(8'h02);
        rd_exp(1'b0, 8'h04, 32'h01, "R4 clear insert");
        check("R7 irq low", 32'(irq), 32'h0);

        // R5 eject
        wr_ctl(8'h08);
        rd_exp(1'b0, 8'h04, 32'h04, "R5 eject");
        check("R7 irq on remove", 32'(irq), 32'h1);
        wr_ctl(8'h04);
        rd_exp(1'b0, 8'h04, 32'h00, "R4 clear remove");
        check("R7 irq cleared", 32'(irq), 32'h0);
        wr_sel(32'd2);
        wr_ctl(8'h08);
        rd_exp(1'b0, 8'h04, 32'h00, "R5 eject on disabled slot");
        check("R5 irq stays low", 32'(irq), 32'h0);

        // R8 R9 scan ordering, wrap, stall length
        pulse_add(1);
        pulse_add(6);
        wr_sel(32'd3);
        scan_and_count(stall);
        check("R9 stall cycles", 32'(stall), 32'(N + 1));
        rd_exp(1'b1, 8'h08, 32'd6, "R8 scan ascending");
        scan_and_count(stall);
        rd_exp(1'b1, 8'h08, 32'd1, "R8 scan wraps");
        wr_ctl(8'h02);
        wr_sel(32'd6);
        scan_and_count(stall);
        rd_exp(1'b1, 8'h08, 32'd6, "R8 selected slot tested last");
        wr_ctl(8'h02);
        scan_and_count(stall);
        rd_exp(1'b1, 8'h08, 32'd6, "R8 no event keeps selector");

        // R12 out of range selector
        pulse_add(0);
        wr_sel(32'd20);
        wr_ctl(8'h0A);
        rd_exp(1'b0, 8'h04, 32'h0, "R12 status out of range");
        scan_and_count(stall);
        rd_exp(1'b1, 8'h08, 32'd0, "R8 scan from out of range");
        rd_exp(1'b0, 8'h04, 32'h03, "R12 control write ignored");

        // R10 R11 OST registers and commands
        wr_cmd(8'h01);
        xfer(1'b1, 1'b1, 8'h08, 32'hA5A5_0001);
        check("R10 ost_event", ost_event, 32'hA5A5_0001);
        check("R10 no notify on event", 32'(ost_notify), 32'h0);
        rd_exp(1'b1, 8'h08, 32'hFFFF_FFFF, "R11 read cmd1");
        wr_cmd(8'h02);
        xfer(1'b1, 1'b1, 8'h08, 32'h0000_0042);
        check("R10 notify high", 32'(ost_notify), 32'h1);
        check("R10 ost_status", ost_status, 32'h0000_0042);
        @(negedge clk);
        check("R10 notify one cycle", 32'(ost_notify), 32'h0);
        wr_cmd(8'h07);
        rd_exp(1'b1, 8'h08, 32'hFFFF_FFFF, "R11 read cmd7");

        // R13 reserved, outside, wrong width
        wr_ctl(8'h02);
        rd_exp(1'b0, 8'h05, 32'h0, "R13 read 0x5");
        rd_exp(1'b1, 8'h00, 32'h0, "R13 read 0x0");
        rd_exp(1'b1, 8'h20, 32'h0, "R13 read outside");
        rd_exp(1'b1, 8'h04, 32'h0, "R13 dword read at 0x4");
        xfer(1'b1, 1'b0, 8'h00, 32'd5);
        xfer(1'b1, 1'b1, 8'h30, 32'd5);
        xfer(1'b1, 1'b0, 8'h06, 32'h0);
        xfer(1'b1, 1'b0, 8'h08, 32'h0000_0099);
        check("R13 byte write at 0x8 ignored", ost_status, 32'h0000_0042);
        scan_and_count(stall);
        rd_exp(1'b1, 8'h08, 32'd0, "R13 selector untouched");

        repeat (3) @(negedge clk);
        check("R14 all responses seen", 32'(exp_q.size()), 32'h0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule